// File: doc/BRIEF.md
# Cascadable Datapath Slice

This block is a narrow slice of a processor datapath. Identical slices are placed side by side to build a word of any width. Every slice receives the same 8-bit instruction from one shared decoder. The carry output of each slice ripples into the carry input of the next slice. Each slice holds four registers: three general registers and a program counter. The program counter lives in the same register file as the others and is advanced by an ordinary increment instruction.

Setting the top instruction bit switches the slice into port mode. In port mode the register file is left alone. Operand B of the ALU comes from the port data input, and the ALU result is presented on the port data output. The port address is taken straight from the instruction. The shared decoder is outside the block. It drives the carry input of the least significant slice: high for subtract and increment, low otherwise.

Top module: `datapath_slice`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero.
- R2: In register mode (instr[7]=0), instr[4:3] selects the destination and operand A, and instr[6:5] selects operand B, with encoding 0=A, 1=B, 2=C, 3=PC. On each clock edge the ALU result is written to the destination register.
- R3: instr[2:0] selects the ALU function: 000 add, 001 subtract, 010 and, 011 or, 100 xor, 101 not A, 110 pass B, 111 increment A.
- R4: Add computes A+B+carryIn, subtract computes A+~B+carryIn, and increment computes A+carryIn. carryOut is the carry out of that sum, so chained slices give correct word-wide sums and differences; for subtract, carryOut=1 means no borrow.
- R5: For the logic functions (and, or, xor, not A, pass B), carryOut is 0.
- R6: In port mode (instr[7]=1), operand A is zero and operand B is ioDataIn. The ALU result appears on ioDataOut, and no register changes.
- R7: ioAddr always equals instr[6:3]. ioDataOut is zero whenever instr[7] is 0.
- R8: sliceBus shows the current ALU result combinationally in both modes.
- R9: The program counter is an ordinary register. An increment with destination PC and carry 1 into the lowest slice advances the whole word by one, wrapping from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 8 | Shared instruction word |
| carryIn | input | 1 | Carry from the lower slice, or from the decoder for the lowest slice |
| ioDataIn | input | SLICE_W | Port data feeding operand B in port mode |
| carryOut | output | 1 | Carry to the next slice |
| ioAddr | output | 4 | Port address from instruction bits 6..3 |
| ioDataOut | output | SLICE_W | ALU result in port mode, zero otherwise |
| sliceBus | output | SLICE_W | Current ALU result |

## Verification
The bench builds the block with SLICE_W=4 and chains two instances into an 8-bit word. This places the slice boundary between bits 3 and 4, where add and subtract carries, borrows and the program-counter wrap from 0xFF to 0x00 all have to cross between instances. Registers are loaded only through the instruction set, by clearing with xor and then repeatedly doubling and incrementing. The 8-bit word keeps these load sequences short while still exercising every operand pattern near the boundary.

// File: rtl/slice_pkg.sv
package slice_pkg;
  localparam int INSTR_W   = 8;
  localparam int NUM_REGS  = 4;
  localparam int REG_SEL_W = $clog2(NUM_REGS);
  localparam int IO_ADDR_W = 4;
  localparam int OP_W      = 3;
  // instruction field positions
  localparam int OP_LSB      = 0;
  localparam int DST_LSB     = 3;
  localparam int SRC_LSB     = DST_LSB + REG_SEL_W;
  localparam int IO_ADDR_LSB = 3;
  localparam int IO_MODE_BIT = INSTR_W - 1;
  localparam int PC_INDEX    = NUM_REGS - 1;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'b000,
    OP_SUB   = 3'b001,
    OP_AND   = 3'b010,
    OP_OR    = 3'b011,
    OP_XOR   = 3'b100,
    OP_NOTA  = 3'b101,
    OP_PASSB = 3'b110,
    OP_INCA  = 3'b111
  } aluOp_e;

  typedef struct packed {
    logic                 ioMode;
    logic                 regWrite;
    logic [REG_SEL_W-1:0] dstSel;
    logic [REG_SEL_W-1:0] srcSel;
    aluOp_e               aluOp;
    logic [IO_ADDR_W-1:0] ioAddr;
  } sliceCtrl_t;
endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output sliceCtrl_t         ctrl
);
  always_comb begin
    ctrl.ioMode   = instr[IO_MODE_BIT];
    ctrl.regWrite = ~instr[IO_MODE_BIT];
    ctrl.dstSel   = instr[DST_LSB +: REG_SEL_W];
    ctrl.srcSel   = instr[SRC_LSB +: REG_SEL_W];
    ctrl.aluOp    = aluOp_e'(instr[OP_LSB +: OP_W]);
    ctrl.ioAddr   = instr[IO_ADDR_LSB +: IO_ADDR_W];
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  aluOp_e           op,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             cin,
  output logic [WIDTH-1:0] result,
  output logic             cout
);
  localparam int SUM_W = WIDTH + 1;

  logic [SUM_W-1:0] addend;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] cinExt;

  always_comb begin
    cinExt = {{WIDTH{1'b0}}, cin};
    unique case (op)
      OP_SUB:  addend = {1'b0, ~opB};
      OP_INCA: addend = '0;
      default: addend = {1'b0, opB};
    endcase
    sum = {1'b0, opA} + addend + cinExt;
  end

  always_comb begin
    cout = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB, OP_INCA: begin
        result = sum[WIDTH-1:0];
        cout   = sum[WIDTH];
      end
      OP_AND:   result = opA & opB;
      OP_OR:    result = opA | opB;
      OP_XOR:   result = opA ^ opB;
      OP_NOTA:  result = ~opA;
      OP_PASSB: result = opB;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sliceCtrl_t       ctrl,
  input  logic             carryIn,
  input  logic [WIDTH-1:0] ioDataIn,
  output logic [WIDTH-1:0] aluResult,
  output logic             carryOut
);
  logic [NUM_REGS-1:0][WIDTH-1:0] regFile;
  logic [NUM_REGS-1:0]            wrEn;
  logic [WIDTH-1:0]               operandA;
  logic [WIDTH-1:0]               operandB;

  always_comb begin
    operandA = ctrl.ioMode ? '0 : regFile[ctrl.dstSel];
    operandB = ctrl.ioMode ? ioDataIn : regFile[ctrl.srcSel];
  end

  slice_alu #(.WIDTH(WIDTH)) alu_i (
    .op     (ctrl.aluOp),
    .opA    (operandA),
    .opB    (operandB),
    .cin    (carryIn),
    .result (aluResult),
    .cout   (carryOut)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign wrEn[r] = ctrl.regWrite && (ctrl.dstSel == REG_SEL_W'(r));
    always_ff @(posedge clk) begin
      if (rst)          regFile[r] <= '0;
      else if (wrEn[r]) regFile[r] <= aluResult;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (regFile == '0));
  // R2
  dst_write_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.ioMode |=> (regFile[$past(ctrl.dstSel)] == $past(aluResult)));
  // R6
  io_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.ioMode |=> (regFile == $past(regFile)));
  // R2
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wrEn));
endmodule

// File: rtl/datapath_slice.sv
module datapath_slice
  import slice_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         instr,
  input  logic               carryIn,
  input  logic [SLICE_W-1:0] ioDataIn,
  output logic               carryOut,
  output logic [3:0]         ioAddr,
  output logic [SLICE_W-1:0] ioDataOut,
  output logic [SLICE_W-1:0] sliceBus
);
  sliceCtrl_t       ctrl;
  logic [SLICE_W-1:0] aluResult;

  slice_ctrl ctrl_i (
    .instr (instr),
    .ctrl  (ctrl)
  );

  slice_datapath #(.WIDTH(SLICE_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .carryIn   (carryIn),
    .ioDataIn  (ioDataIn),
    .aluResult (aluResult),
    .carryOut  (carryOut)
  );

  assign ioAddr    = ctrl.ioAddr;
  assign ioDataOut = ctrl.ioMode ? aluResult : '0;
  assign sliceBus  = aluResult;

  // R7
  io_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instr[7] |-> (ioDataOut == '0));
endmodule

// File: tb/datapath_slice_tb.sv
module datapath_slice_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int NS = 2;
  localparam int WW = SW * NS;

  localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, AND_ = 3'd2, OR_ = 3'd3,
                         XOR_ = 3'd4, NOTA = 3'd5, PASSB = 3'd6, INCA = 3'd7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] instr = 8'h00;
  logic [WW-1:0] ioWord = '0;
  logic lsbCarry = 1'b0;
  logic [NS:0] carryChain;
  logic [NS-1:0][3:0] ioAddrS;
  logic [WW-1:0] busWord;
  logic [WW-1:0] ioOutWord;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [WW-1:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign carryChain[0] = lsbCarry;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    datapath_slice #(.SLICE_W(SW)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .instr     (instr),
      .carryIn   (carryChain[s]),
      .ioDataIn  (ioWord[s*SW +: SW]),
      .carryOut  (carryChain[s+1]),
      .ioAddr    (ioAddrS[s]),
      .ioDataOut (ioOutWord[s*SW +: SW]),
      .sliceBus  (busWord[s*SW +: SW])
    );
  end

  function automatic logic [WW:0] aluRef(input logic [2:0] op,
                                          input logic [WW-1:0] a, input logic [WW-1:0] b);
    case (op)
      ADD:   aluRef = {1'b0, a} + {1'b0, b};
      SUB:   aluRef = {1'b0, a} + {1'b0, ~b} + 1;
      INCA:  aluRef = {1'b0, a} + 1;
      AND_:  aluRef = {1'b0, a & b};
      OR_:   aluRef = {1'b0, a | b};
      XOR_:  aluRef = {1'b0, a ^ b};
      NOTA:  aluRef = {1'b0, ~a};
      default: aluRef = {1'b0, b};
    endcase
  endfunction

  function automatic logic [7:0] mk(input logic [2:0] op, input logic [1:0] dst, input logic [1:0] src);
    mk = {1'b0, src, dst, op};
  endfunction

  function automatic logic [7:0] mkIo(input logic [2:0] op, input logic [3:0] addr);
    mkIo = {1'b1, addr, op};
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic runInstr(input logic [7:0] ins, input logic [WW-1:0] ioIn, input string req);
    logic io;
    logic [1:0] dst, src;
    logic [WW-1:0] a, b;
    logic [WW:0] r;
    @(negedge clk);
    instr = ins;
    ioWord = ioIn;
    lsbCarry = (ins[2:0] == SUB) || (ins[2:0] == INCA);
    #1;
    io = ins[7];
    dst = ins[4:3];
    src = ins[6:5];
    a = io ? '0 : model[dst];
    b = io ? ioIn : model[src];
    r = aluRef(ins[2:0], a, b);
    check(req, "sliceBus", 16'(busWord), 16'(r[WW-1:0]));
    if (ins[2:0] == ADD || ins[2:0] == SUB || ins[2:0] == INCA)
      check("R4", "carryOut", 16'(carryChain[NS]), 16'(r[WW]));
    else
      check("R5", "carryOut", 16'(carryChain[NS]), 16'h0);
    if (io) check("R6", "ioDataOut", 16'(ioOutWord), 16'(r[WW-1:0]));
    else    check("R7", "ioDataOut", 16'(ioOutWord), 16'h0);
    for (int s = 0; s < NS; s++) check("R7", "ioAddr", 16'(ioAddrS[s]), 16'(ins[6:3]));
    @(posedge clk);
    if (!io) model[dst] = r[WW-1:0];
  endtask

  task automatic readReg(input logic [1:0] r, input string req);
    runInstr(mk(PASSB, r, r), '0, req);
  endtask

  task automatic loadReg(input logic [1:0] r, input logic [WW-1:0] val);
    runInstr(mk(XOR_, r, r), '0, "R2");
    for (int i = WW - 1; i >= 0; i--) begin
      runInstr(mk(ADD, r, r), '0, "R2");
      if (val[i]) runInstr(mk(INCA, r, r), '0, "R9");
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    for (int i = 0; i < 4; i++) model[i] = '0;
    // R1: reset state
    doReset();
    for (int r = 0; r < 4; r++) readReg(2'(r), "R1");

    // R4: carries across the slice boundary
    loadReg(2'd0, 8'h0F);
    loadReg(2'd1, 8'h01);
    runInstr(mk(ADD, 2'd0, 2'd1), '0, "R4");
    loadReg(2'd0, 8'hFF);
    runInstr(mk(ADD, 2'd0, 2'd1), '0, "R4");
    loadReg(2'd0, 8'h10);
    runInstr(mk(SUB, 2'd0, 2'd1), '0, "R4");
    loadReg(2'd0, 8'h00);
    runInstr(mk(SUB, 2'd0, 2'd1), '0, "R4");

    // R3 / R5: logic functions
    loadReg(2'd0, 8'hA5);
    loadReg(2'd2, 8'h3C);
    for (int op = 2; op <= 6; op++) begin
      runInstr(mk(3'(op), 2'd1, 2'd2), '0, "R3");
      readReg(2'd0, "R3");
    end

    // R9: program counter wrap
    loadReg(2'd3, 8'hFE);
    runInstr(mk(INCA, 2'd3, 2'd0), '0, "R9");
    runInstr(mk(INCA, 2'd3, 2'd0), '0, "R9");
    readReg(2'd3, "R9");

    // R6: port mode leaves registers untouched
    for (int op = 0; op < 8; op++) begin
      runInstr(mkIo(3'(op), 4'(op * 2 + 1)), 8'h9C, "R6");
    end
    runInstr(mkIo(PASSB, 4'h0), 8'hFF, "R6");
    runInstr(mkIo(PASSB, 4'hF), 8'h01, "R6");
    for (int r = 0; r < 4; r++) readReg(2'(r), "R6");

    // R8: random mix
    for (int n = 0; n < 400; n++) begin
      runInstr(8'($urandom), WW'($urandom), "R8");
    end

    // R1: reset in mid-run
    doReset();
    for (int r = 0; r < 4; r++) readReg(2'(r), "R1");

    finished = 1;
    summary();
    $finish;
  end
endmodule